// File: doc/BRIEF.md
# Dithered Switching-Period Generator

The block sets the length of each switching cycle for a PWM counter. With dithering on, the switching frequency is spread across a band, which lowers EMI peaks. It holds a programmed nominal period and, while dithering is enabled, moves the period up and down in a linear triangle between 7/8 and 9/8 of that nominal value. That period range gives a switching frequency of roughly 89% to 114% of nominal. A second setting gives the number of switching cycles a half sweep (minimum to maximum) should take, and the per-cycle step follows from it.

The block contains its own cycle counter. It outputs the period word of the cycle now running and a one-clock strobe on the first clock of every switching cycle. The period changes only at cycle boundaries, so no cycle is ever cut short. The sweep runs as a three-state machine. `ST_FIXED` holds the nominal period. `ST_RISE` adds the step each cycle, and `ST_FALL` subtracts it. The transitions are as follows:

- *enable* (`ST_FIXED`→`ST_RISE`, taken at a boundary with the enable set)
- *top reached* (`ST_RISE`→`ST_FALL`, taken when the next value would reach the upper bound)
- *bottom reached* (`ST_FALL`→`ST_RISE`, taken when the next value would reach the lower bound)
- *disable* (any state→`ST_FIXED`, taken at a boundary with the enable clear)

Top module: `dpp_period_gen`

## Requirements
- R1: While `rst` is high, `period_word` equals `nom_period` and `cyc_start` is low. On the first clock after `rst` falls, `cyc_start` is high and the sweep direction is upward.
- R2: If `dith_en` is low at a cycle boundary, the next cycle's `period_word` equals `nom_period`.
- R3: The lower bound is lo = N − floor(N/8) and the upper bound is hi = N + floor(N/8), where N is `nom_period`. While sweeping, `period_word` never leaves [lo, hi].
- R4: The step is max(1, floor(2·floor(N/8) / H)), where H is `half_sweep_cycles`. A value of 0 for H is treated as 1.
- R5: When rising, the next period is the current period plus the step, clamped to hi; reaching hi turns the sweep downward. When falling, the next period is the current period minus the step, clamped to lo; reaching lo turns the sweep upward.
- R6: Every switching cycle lasts exactly `period_word` clocks. `period_word` is constant within a cycle, and `cyc_start` is high only on the first clock of each cycle.
- R7: `dith_en` is sampled only at cycle boundaries. After a disable, the next cycle is nominal, and a later enable resumes upward from nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dith_en | input | 1 | Dither enable, sampled at cycle boundaries |
| nom_period | input | PW (16) | Nominal switching period in clocks |
| half_sweep_cycles | input | DW (8) | Switching cycles per half triangle (0 acts as 1) |
| period_word | output | PW+1 (17) | Period of the current switching cycle |
| cyc_start | output | 1 | High on the first clock of each switching cycle |

## Verification
The following are checked by assertions on every clock:
- the band limits while sweeping
- the bounded step between consecutive periods while enabled
- the nominal value after a disabled boundary
- the period word staying put between boundaries
- the counter staying below the period

Only the bench scenarios can show the rest. These are the exact triangle sequence, including the turns at each clamp, the step values for different nominal and half-sweep settings, the precise length of each cycle, and the resumption from nominal after the enable is toggled.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
    typedef enum logic [1:0] {
        ST_FIXED = 2'd0,
        ST_RISE  = 2'd1,
        ST_FALL  = 2'd2
    } sweep_state_t;
endpackage

// File: rtl/dpp_bounds.sv
module dpp_bounds #(
    parameter int PW = 16,
    parameter int DW = 8,
    localparam int OW = PW + 1
) (
    input  logic [PW-1:0] nom,
    input  logic [DW-1:0] half_cycles,
    output logic [OW-1:0] lo,
    output logic [OW-1:0] hi,
    output logic [PW-1:0] step
);
    logic [PW-1:0] eighth;
    logic [PW-1:0] span;
    logic [PW-1:0] divisor;
    logic [PW-1:0] quot;

    always_comb begin
        eighth  = nom >> 3;
        lo      = {1'b0, nom} - {1'b0, eighth};
        hi      = {1'b0, nom} + {1'b0, eighth};
        span    = eighth << 1;
        divisor = (half_cycles == '0) ? PW'(1) : PW'(half_cycles);
        quot    = span / divisor;
        step    = (quot == '0) ? PW'(1) : quot;
    end

    always_comb begin
        a_r3_band_order: assert (lo <= hi);
    end
endmodule

// File: rtl/dpp_cycle_counter.sv
module dpp_cycle_counter #(
    parameter int OW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [OW-1:0] per,
    output logic          wrap,
    output logic          start
);
    logic [OW-1:0] cnt_q;
    logic [OW:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + (OW+1)'(1);
        wrap    = !rst && (cnt_inc >= {1'b0, per});
        start   = !rst && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_inc[OW-1:0];
    end

    a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) || (cnt_q < per));
endmodule

// File: rtl/dpp_sweep.sv
module dpp_sweep
    import dpp_pkg::*;
#(
    parameter int PW = 16,
    localparam int OW = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wrap,
    input  logic [PW-1:0] nom,
    input  logic [OW-1:0] lo,
    input  logic [OW-1:0] hi,
    input  logic [PW-1:0] step,
    output logic [OW-1:0] per
);
    sweep_state_t  state_q, state_d;
    logic [OW-1:0] per_q, per_d;
    logic [OW:0]   up_sum;
    logic [OW:0]   dn_lim;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FIXED;
            per_q   <= {1'b0, nom};
        end else begin
            state_q <= state_d;
            per_q   <= per_d;
        end
    end

    // next state and period
    always_comb begin
        up_sum  = {1'b0, per_q} + (OW+1)'(step);
        dn_lim  = {1'b0, lo} + (OW+1)'(step);
        state_d = state_q;
        per_d   = per_q;
        if (wrap) begin
            if (!en) begin
                state_d = ST_FIXED;
                per_d   = {1'b0, nom};
            end else begin
                unique case (state_q)
                    ST_FIXED, ST_RISE: begin
                        if (up_sum >= {1'b0, hi}) begin
                            state_d = ST_FALL;
                            per_d   = hi;
                        end else begin
                            state_d = ST_RISE;
                            per_d   = up_sum[OW-1:0];
                        end
                    end
                    ST_FALL: begin
                        if ({1'b0, per_q} <= dn_lim) begin
                            state_d = ST_RISE;
                            per_d   = lo;
                        end else begin
                            state_d = ST_FALL;
                            per_d   = per_q - OW'(step);
                        end
                    end
                    default: begin
                        state_d = ST_FIXED;
                        per_d   = {1'b0, nom};
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        per = per_q;
    end

    a_r3_within_band: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_FIXED) |-> (per_q >= lo && per_q <= hi));

    a_r2_nominal_when_off: assert property (@(posedge clk) disable iff (rst)
        (wrap && !en) |=> (per_q == {1'b0, $past(nom)}));

    a_r5_step_limit: assert property (@(posedge clk) disable iff (rst)
        (wrap && en) |=> (((per_q >= $past(per_q)) ? (per_q - $past(per_q))
                                                  : ($past(per_q) - per_q)) <= OW'(step)));
endmodule

// File: rtl/dpp_period_gen.sv
module dpp_period_gen #(
    parameter int PW = 16,
    parameter int DW = 8,
    localparam int OW = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dith_en,
    input  logic [PW-1:0] nom_period,
    input  logic [DW-1:0] half_sweep_cycles,
    output logic [OW-1:0] period_word,
    output logic          cyc_start
);
    logic [OW-1:0] lo_b, hi_b;
    logic [PW-1:0] step_b;
    logic          wrap;

    dpp_bounds #(.PW(PW), .DW(DW)) u_bounds (
        .nom         (nom_period),
        .half_cycles (half_sweep_cycles),
        .lo          (lo_b),
        .hi          (hi_b),
        .step        (step_b)
    );

    dpp_sweep #(.PW(PW)) u_sweep (
        .clk  (clk),
        .rst  (rst),
        .en   (dith_en),
        .wrap (wrap),
        .nom  (nom_period),
        .lo   (lo_b),
        .hi   (hi_b),
        .step (step_b),
        .per  (period_word)
    );

    dpp_cycle_counter #(.OW(OW)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .per   (period_word),
        .wrap  (wrap),
        .start (cyc_start)
    );

    a_r6_period_held: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(period_word));

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |-> !cyc_start);
endmodule

// File: tb/dpp_period_gen_bench.sv
module dpp_period_gen_bench;
    localparam int PW = 16;
    localparam int DW = 8;
    localparam int OW = PW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dith_en = 1'b0;
    logic [PW-1:0] nom_period = '0;
    logic [DW-1:0] half_sweep_cycles = '0;
    logic [OW-1:0] period_word;
    logic          cyc_start;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dpp_period_gen #(.PW(PW), .DW(DW)) u_dpp_period_gen (
        .clk               (clk),
        .rst               (rst),
        .dith_en           (dith_en),
        .nom_period        (nom_period),
        .half_sweep_cycles (half_sweep_cycles),
        .period_word       (period_word),
        .cyc_start         (cyc_start)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model of the sweep, from the requirements
    int m_per, m_down, m_lo, m_hi, m_step, m_nom;

    task automatic model_setup(input int nom, input int hc);
        int e;
        int d;
        e      = nom / 8;
        m_nom  = nom;
        m_lo   = nom - e;
        m_hi   = nom + e;
        d      = (hc == 0) ? 1 : hc;
        m_step = (2 * e) / d;
        if (m_step == 0) m_step = 1;
        m_per  = nom;
        m_down = 0;
    endtask

    task automatic model_next(input bit en);
        if (!en) begin
            m_per  = m_nom;
            m_down = 0;
        end else if (m_down == 0) begin
            if (m_per + m_step >= m_hi) begin
                m_per  = m_hi;
                m_down = 1;
            end else m_per = m_per + m_step;
        end else begin
            if (m_per <= m_lo + m_step) begin
                m_per  = m_lo;
                m_down = 0;
            end else m_per = m_per - m_step;
        end
    endtask

    // run one switching cycle: called on the strobe clock, enable applies to this cycle
    task automatic run_cycle(input bit en, input string tag);
        int clks;
        int start_per;
        dith_en   = en;
        clks      = 1;
        start_per = m_per;
        forever begin
            @(negedge clk);
            if (cyc_start) break;
            clks++;
            if (int'(period_word) != start_per)
                check(0, "R6 period changed mid-cycle", int'(period_word), start_per);
        end
        check(clks == start_per, "R6 cycle length", clks, start_per);
        model_next(en);
        check(int'(period_word) == m_per, tag, int'(period_word), m_per);
        if (en)
            check(int'(period_word) >= m_lo && int'(period_word) <= m_hi,
                  "R3 period inside band", int'(period_word), m_lo);
    endtask

    task automatic run_config(input int nom, input int hc);
        rst               = 1'b1;
        dith_en           = 1'b0;
        nom_period        = PW'(nom);
        half_sweep_cycles = DW'(hc);
        model_setup(nom, hc);
        repeat (3) @(negedge clk);
        check(int'(period_word) == nom, "R1 period in reset", int'(period_word), nom);
        check(cyc_start == 1'b0, "R1 strobe low in reset", int'(cyc_start), 0);
        rst = 1'b0;
        #1;
        check(cyc_start == 1'b1, "R1 first strobe after reset", int'(cyc_start), 1);
        // first enabled step is upward from nominal (R1, R4)
        run_cycle(1'b1, "R4 first step up from nominal");
        for (int i = 0; i < 29; i++) run_cycle(1'b1, "R5 triangle sequence");
        run_cycle(1'b0, "R7 disable gives nominal next");
        for (int i = 0; i < 2; i++) run_cycle(1'b0, "R2 nominal while off");
        run_cycle(1'b1, "R7 re-enable resumes upward");
        for (int i = 0; i < 11; i++) run_cycle(1'b1, "R5 triangle after re-enable");
    endtask

    initial begin
        #(10 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        run_config(80, 4);    // step 5
        run_config(80, 0);    // zero treated as one: step 20
        run_config(200, 7);   // step 7, uneven clamp at both ends
        run_config(40, 100);  // step rounds to 0 -> 1
        run_config(9, 3);     // tiny band, step 1
        run_config(1000, 1);  // step equals full swing
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule